// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes configuration words from a single serial data line, timed by the converter word clock, and loads them into a bank of configuration registers whose fields drive the analog front end: receive gain, input selection, external gain pins, filter routing, transmit gain, general-purpose outputs, loopback mode, oversampling-ratio selection, filter cutoff trims, the crystal-oscillator tuning DAC value and the per-module power-down bits.

A frame is sixteen bits long, sent most significant bit first. Its first bit is a low start bit, the next twelve bits are the payload and the last three bits name the register group that the payload replaces. A frame takes effect only once at least sixteen high stop bits have followed it; a low bit before that point opens a new frame and the pending one is dropped. Each accepted write raises a one-cycle strobe together with the group identifier, so the surrounding logic or a bench can follow every update.

Top module: `cfg_word_rx`

## Requirements
- R1: The serial line is sampled on the falling edge of `wclk`; while no frame is open, high bits are ignored and the first low bit sampled is taken as a start bit.
- R2: After the start bit, the next 15 sampled bits are frame bits b14 down to b0 in that order; b2..b0 form the group identifier and b14..b3 form the payload p11..p0 (p0 = b3).
- R3: A frame is committed at the falling edge that samples its 16th consecutive high stop bit; the affected fields change at that edge and not earlier.
- R4: A low bit sampled after a frame's last data bit but before its 16th stop bit discards the frame (no field changes, no strobe) and acts as the start bit of a new frame.
- R5: Identifiers 000 (receive), 001 (transmit), 010 (general), 011 (trim), 100 (tuning DAC) and 101 (power-down) select a group; committed frames with identifier 110 or 111 change no field and raise no strobe.
- R6: Every committed frame with a valid identifier holds `upd` high for exactly one word-clock cycle after the commit edge, with `upd_id` equal to the identifier.
- R7: Group 000 writes `rx_gain` from p4..p0 (code N = N dB, 0 to 31), `rx_insel` from p6..p5, `ext_gain` from p8..p7 and `flt_route` from p10..p9.
- R8: Group 001 writes `tx_gain` from p3..p0 (code 0 means -15 dB, code 15 means 0 dB, 1 dB per step) and `gpo` from p6..p4.
- R9: Group 010 writes `loop_mode` from p1..p0, `vdac_en` from p2, `osr_half` from p3 (0 selects ratio 4, 1 selects ratio 2) and `vcxo_filt` from p4.
- R10: Group 011 writes the two's-complement cutoff trims `lo_cut` from p2..p0 and `hi_cut` from p5..p3, each from -4 (100) to +3 (011), and the test field from p9..p6.
- R11: `test_ctl` shows the stored test field only while `test_en` is high and reads zero while it is low, whatever was written.
- R12: After reset: `rx_gain`, `tx_gain` = 0, `rx_insel` = 11, `osr_half` = 0, both cutoffs = 0, `vdac_en` = 0, and every other field and `upd` = 0.
- R13: Group 100 writes `vdac_val` from p7..p0; group 101 writes `pd` from p11..p0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Word clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial configuration data |
| test_en | input | 1 | Test mode enable; low forces the test field output to zero |
| rx_gain | output | 5 | Receive gain code, dB |
| rx_insel | output | 2 | Receive input select |
| ext_gain | output | 2 | External gain control pins |
| flt_route | output | 2 | Filter routing select |
| tx_gain | output | 4 | Transmit gain code, code 0 = -15 dB |
| gpo | output | 3 | General-purpose outputs |
| loop_mode | output | 2 | Loopback mode |
| vdac_en | output | 1 | Tuning DAC enable |
| osr_half | output | 1 | Oversampling ratio select, 1 = ratio 2 |
| vcxo_filt | output | 1 | Tuning path filter select |
| lo_cut | output | 3 | Signed low-band filter cutoff trim |
| hi_cut | output | 3 | Signed high-band filter cutoff trim |
| test_ctl | output | 4 | Test field, gated by test_en |
| vdac_val | output | 8 | Tuning DAC value |
| pd | output | 12 | Per-module power-down bits |
| upd | output | 1 | One-cycle update strobe |
| upd_id | output | 3 | Group identifier of the last update |

## Verification
On every cycle the assertions check that the strobe never lasts two cycles, that it never carries an identifier outside the six groups, that the test field stays zero while test mode is off, and that a receive gain, transmit gain, oversampling or power-down field changes only in the cycle the strobe reports its own group. Field bit positions, the commit landing on exactly the sixteenth stop bit, the dropping of a frame cut short by a low bit, the silence of unused identifiers and the reset values can only be shown by the bench's frame scenarios.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int ID_W = 3;
  typedef enum logic [ID_W-1:0] {
    GRP_RX   = 3'd0,
    GRP_TX   = 3'd1,
    GRP_GEN  = 3'd2,
    GRP_TRIM = 3'd3,
    GRP_VDAC = 3'd4,
    GRP_PD   = 3'd5
  } grp_e;
  typedef enum logic [1:0] {ST_HUNT, ST_DATA, ST_STOP} rx_state_e;
endpackage

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_rx_pkg::*;
#(
  parameter int FRAME_W  = 16,
  parameter int STOP_MIN = 16
) (
  input  logic               wclk,
  input  logic               rst,
  input  logic               sdi,
  output logic [FRAME_W-2:0] word_o,
  output logic               commit_o
);
  localparam int BODY_W = FRAME_W - 1;
  localparam int CNT_W  = $clog2(BODY_W);
  localparam int SCNT_W = $clog2(STOP_MIN + 1);
  localparam logic [CNT_W-1:0]  BODY_LAST = CNT_W'(BODY_W - 1);
  localparam logic [SCNT_W-1:0] STOP_LAST = SCNT_W'(STOP_MIN - 1);

  rx_state_e          st;
  logic [CNT_W-1:0]   bit_cnt;
  logic [SCNT_W-1:0]  stop_cnt;
  logic [BODY_W-1:0]  shreg;

  always_ff @(negedge wclk) begin
    if (rst) begin
      st       <= ST_HUNT;
      bit_cnt  <= '0;
      stop_cnt <= '0;
      shreg    <= '0;
    end else begin
      unique case (st)
        ST_HUNT: if (!sdi) begin
          st      <= ST_DATA;
          bit_cnt <= '0;
        end
        ST_DATA: begin
          shreg <= {shreg[BODY_W-2:0], sdi};
          if (bit_cnt == BODY_LAST) begin
            st       <= ST_STOP;
            stop_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (!sdi) begin
            st      <= ST_DATA;
            bit_cnt <= '0;
          end else if (stop_cnt == STOP_LAST) begin
            st <= ST_HUNT;
          end else begin
            stop_cnt <= stop_cnt + 1'b1;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  assign commit_o = (st == ST_STOP) && sdi && (stop_cnt == STOP_LAST);
  assign word_o   = shreg;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_rx_pkg::*;
#(
  parameter int PAY_W  = 12,
  parameter int RXG_W  = 5,
  parameter int TXG_W  = 4,
  parameter int GPO_W  = 3,
  parameter int CUT_W  = 3,
  parameter int TST_W  = 4,
  parameter int VDAC_W = 8,
  parameter int PD_W   = 12
) (
  input  logic                    wclk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [PAY_W+ID_W-1:0]   word,
  input  logic                    test_en,
  output logic [RXG_W-1:0]        rx_gain,
  output logic [1:0]              rx_insel,
  output logic [1:0]              ext_gain,
  output logic [1:0]              flt_route,
  output logic [TXG_W-1:0]        tx_gain,
  output logic [GPO_W-1:0]        gpo,
  output logic [1:0]              loop_mode,
  output logic                    vdac_en,
  output logic                    osr_half,
  output logic                    vcxo_filt,
  output logic signed [CUT_W-1:0] lo_cut,
  output logic signed [CUT_W-1:0] hi_cut,
  output logic [TST_W-1:0]        test_ctl,
  output logic [VDAC_W-1:0]       vdac_val,
  output logic [PD_W-1:0]         pd,
  output logic                    upd,
  output logic [ID_W-1:0]         upd_id
);
  localparam int INS_LSB = RXG_W;
  localparam int EXT_LSB = RXG_W + 2;
  localparam int RTE_LSB = RXG_W + 4;
  localparam int GPO_LSB = TXG_W;
  localparam int HI_LSB  = CUT_W;
  localparam int TST_LSB = 2 * CUT_W;

  logic [PAY_W-1:0] pay;
  logic [ID_W-1:0]  gid;
  logic [TST_W-1:0] tst_q;

  assign pay = word[PAY_W+ID_W-1:ID_W];
  assign gid = word[ID_W-1:0];

  always_ff @(negedge wclk) begin
    if (rst) begin
      rx_gain   <= '0;
      rx_insel  <= 2'b11;
      ext_gain  <= '0;
      flt_route <= '0;
      tx_gain   <= '0;
      gpo       <= '0;
      loop_mode <= '0;
      vdac_en   <= 1'b0;
      osr_half  <= 1'b0;
      vcxo_filt <= 1'b0;
      lo_cut    <= '0;
      hi_cut    <= '0;
      tst_q     <= '0;
      vdac_val  <= '0;
      pd        <= '0;
      upd       <= 1'b0;
      upd_id    <= '0;
    end else begin
      upd <= 1'b0;
      if (commit) begin
        unique case (gid)
          GRP_RX: begin
            rx_gain   <= pay[RXG_W-1:0];
            rx_insel  <= pay[INS_LSB+1:INS_LSB];
            ext_gain  <= pay[EXT_LSB+1:EXT_LSB];
            flt_route <= pay[RTE_LSB+1:RTE_LSB];
          end
          GRP_TX: begin
            tx_gain <= pay[TXG_W-1:0];
            gpo     <= pay[GPO_LSB+GPO_W-1:GPO_LSB];
          end
          GRP_GEN: begin
            loop_mode <= pay[1:0];
            vdac_en   <= pay[2];
            osr_half  <= pay[3];
            vcxo_filt <= pay[4];
          end
          GRP_TRIM: begin
            lo_cut <= pay[CUT_W-1:0];
            hi_cut <= pay[HI_LSB+CUT_W-1:HI_LSB];
            tst_q  <= pay[TST_LSB+TST_W-1:TST_LSB];
          end
          GRP_VDAC: vdac_val <= pay[VDAC_W-1:0];
          GRP_PD:   pd       <= pay[PD_W-1:0];
          default: ;
        endcase
        if (gid <= ID_W'(GRP_PD)) begin
          upd    <= 1'b1;
          upd_id <= gid;
        end
      end
    end
  end

  assign test_ctl = test_en ? tst_q : '0;
endmodule

// File: rtl/cfg_word_rx.sv
module cfg_word_rx #(
  parameter int FRAME_W  = 16,
  parameter int STOP_MIN = 16,
  parameter int RXG_W    = 5,
  parameter int TXG_W    = 4,
  parameter int GPO_W    = 3,
  parameter int CUT_W    = 3,
  parameter int TST_W    = 4,
  parameter int VDAC_W   = 8,
  parameter int PD_W     = 12
) (
  input  logic                    wclk,
  input  logic                    rst,
  input  logic                    sdi,
  input  logic                    test_en,
  output logic [RXG_W-1:0]        rx_gain,
  output logic [1:0]              rx_insel,
  output logic [1:0]              ext_gain,
  output logic [1:0]              flt_route,
  output logic [TXG_W-1:0]        tx_gain,
  output logic [GPO_W-1:0]        gpo,
  output logic [1:0]              loop_mode,
  output logic                    vdac_en,
  output logic                    osr_half,
  output logic                    vcxo_filt,
  output logic signed [CUT_W-1:0] lo_cut,
  output logic signed [CUT_W-1:0] hi_cut,
  output logic [TST_W-1:0]        test_ctl,
  output logic [VDAC_W-1:0]       vdac_val,
  output logic [PD_W-1:0]         pd,
  output logic                    upd,
  output logic [2:0]              upd_id
);
  localparam int ID_W  = cfg_rx_pkg::ID_W;
  localparam int PAY_W = FRAME_W - 1 - ID_W;

  logic [FRAME_W-2:0] word;
  logic               commit;

  cfg_frame_rx #(.FRAME_W(FRAME_W), .STOP_MIN(STOP_MIN)) u_frame (
    .wclk(wclk), .rst(rst), .sdi(sdi), .word_o(word), .commit_o(commit)
  );

  cfg_reg_bank #(
    .PAY_W(PAY_W), .RXG_W(RXG_W), .TXG_W(TXG_W), .GPO_W(GPO_W),
    .CUT_W(CUT_W), .TST_W(TST_W), .VDAC_W(VDAC_W), .PD_W(PD_W)
  ) u_bank (
    .wclk(wclk), .rst(rst), .commit(commit), .word(word), .test_en(test_en),
    .rx_gain(rx_gain), .rx_insel(rx_insel), .ext_gain(ext_gain),
    .flt_route(flt_route), .tx_gain(tx_gain), .gpo(gpo),
    .loop_mode(loop_mode), .vdac_en(vdac_en), .osr_half(osr_half),
    .vcxo_filt(vcxo_filt), .lo_cut(lo_cut), .hi_cut(hi_cut),
    .test_ctl(test_ctl), .vdac_val(vdac_val), .pd(pd),
    .upd(upd), .upd_id(upd_id)
  );
endmodule

// File: rtl/cfg_word_rx_chk.sv
module cfg_word_rx_chk #(
  parameter int RXG_W = 5,
  parameter int TXG_W = 4,
  parameter int TST_W = 4,
  parameter int PD_W  = 12
) (
  input logic             wclk,
  input logic             rst,
  input logic             test_en,
  input logic [RXG_W-1:0] rx_gain,
  input logic [TXG_W-1:0] tx_gain,
  input logic             osr_half,
  input logic [TST_W-1:0] test_ctl,
  input logic [PD_W-1:0]  pd,
  input logic             upd,
  input logic [2:0]       upd_id
);
  logic armed;
  always_ff @(negedge wclk) armed <= !rst;

  AST_STROBE_SINGLE: assert property (@(negedge wclk) disable iff (rst || !armed)
    upd |=> !upd); // R6
  AST_ID_KNOWN: assert property (@(negedge wclk) disable iff (rst || !armed)
    upd |-> (upd_id <= 3'd5)); // R5
  AST_TEST_GATED: assert property (@(negedge wclk) disable iff (rst || !armed)
    !test_en |-> (test_ctl == '0)); // R11
  AST_RXG_ON_OWN_UPD: assert property (@(negedge wclk) disable iff (rst || !armed)
    !$stable(rx_gain) |-> (upd && upd_id == 3'd0)); // R7
  AST_TXG_ON_OWN_UPD: assert property (@(negedge wclk) disable iff (rst || !armed)
    !$stable(tx_gain) |-> (upd && upd_id == 3'd1)); // R8
  AST_OSR_ON_OWN_UPD: assert property (@(negedge wclk) disable iff (rst || !armed)
    !$stable(osr_half) |-> (upd && upd_id == 3'd2)); // R9
  AST_PD_ON_OWN_UPD: assert property (@(negedge wclk) disable iff (rst || !armed)
    !$stable(pd) |-> (upd && upd_id == 3'd5)); // R13
endmodule

bind cfg_word_rx cfg_word_rx_chk #(
  .RXG_W(RXG_W), .TXG_W(TXG_W), .TST_W(TST_W), .PD_W(PD_W)
) u_chk (
  .wclk(wclk), .rst(rst), .test_en(test_en), .rx_gain(rx_gain),
  .tx_gain(tx_gain), .osr_half(osr_half), .test_ctl(test_ctl), .pd(pd),
  .upd(upd), .upd_id(upd_id)
);

// File: tb/cfg_word_rx_test.sv
module cfg_word_rx_test;
  logic wclk = 1'b0, rst = 1'b1, sdi = 1'b1, test_en = 1'b0;
  logic [4:0] rx_gain; logic [1:0] rx_insel, ext_gain, flt_route;
  logic [3:0] tx_gain; logic [2:0] gpo; logic [1:0] loop_mode;
  logic vdac_en, osr_half, vcxo_filt;
  logic signed [2:0] lo_cut, hi_cut;
  logic [3:0] test_ctl; logic [7:0] vdac_val; logic [11:0] pd;
  logic upd; logic [2:0] upd_id;

  cfg_word_rx uut (
    .wclk(wclk), .rst(rst), .sdi(sdi), .test_en(test_en),
    .rx_gain(rx_gain), .rx_insel(rx_insel), .ext_gain(ext_gain),
    .flt_route(flt_route), .tx_gain(tx_gain), .gpo(gpo),
    .loop_mode(loop_mode), .vdac_en(vdac_en), .osr_half(osr_half),
    .vcxo_filt(vcxo_filt), .lo_cut(lo_cut), .hi_cut(hi_cut),
    .test_ctl(test_ctl), .vdac_val(vdac_val), .pd(pd),
    .upd(upd), .upd_id(upd_id)
  );

  always #2 wclk = ~wclk;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  logic [2:0] exp_q[$];

  // expected register state
  int m_rxg = 0, m_ins = 3, m_ext = 0, m_rte = 0, m_txg = 0, m_gpo = 0;
  int m_loop = 0, m_ven = 0, m_osr = 0, m_vf = 0, m_lo = 0, m_hi = 0;
  int m_tst = 0, m_vdac = 0, m_pd = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "rx_gain", int'(rx_gain), m_rxg);
    chk(tag, "rx_insel", int'(rx_insel), m_ins);
    chk(tag, "ext_gain", int'(ext_gain), m_ext);
    chk(tag, "flt_route", int'(flt_route), m_rte);
    chk(tag, "tx_gain", int'(tx_gain), m_txg);
    chk(tag, "gpo", int'(gpo), m_gpo);
    chk(tag, "loop_mode", int'(loop_mode), m_loop);
    chk(tag, "vdac_en", int'(vdac_en), m_ven);
    chk(tag, "osr_half", int'(osr_half), m_osr);
    chk(tag, "vcxo_filt", int'(vcxo_filt), m_vf);
    chk(tag, "lo_cut", int'(lo_cut), m_lo);
    chk(tag, "hi_cut", int'(hi_cut), m_hi);
    chk(tag, "test_ctl", int'(test_ctl), test_en ? m_tst : 0);
    chk(tag, "vdac_val", int'(vdac_val), m_vdac);
    chk(tag, "pd", int'(pd), m_pd);
  endtask

  function automatic int sx3(input logic [2:0] v);
    return v[2] ? int'(v) - 8 : int'(v);
  endfunction

  task automatic apply_model(input logic [2:0] id, input logic [11:0] p);
    case (id)
      3'd0: begin m_rxg = p[4:0]; m_ins = p[6:5]; m_ext = p[8:7]; m_rte = p[10:9]; end
      3'd1: begin m_txg = p[3:0]; m_gpo = p[6:4]; end
      3'd2: begin m_loop = p[1:0]; m_ven = p[2]; m_osr = p[3]; m_vf = p[4]; end
      3'd3: begin m_lo = sx3(p[2:0]); m_hi = sx3(p[5:3]); m_tst = p[9:6]; end
      3'd4: m_vdac = p[7:0];
      3'd5: m_pd = p;
      default: ;
    endcase
  endtask

  // driver: shifts start bit, payload, id, then stop bits
  task automatic send(input logic [2:0] id, input logic [11:0] p,
                      input int nstops, input bit expect_commit);
    logic [15:0] w;
    w = {1'b0, p, id};
    if (expect_commit) begin
      apply_model(id, p);
      exp_q.push_back(id);
    end
    for (int i = 15; i >= 0; i--) begin
      @(posedge wclk); sdi = w[i];
    end
    for (int k = 0; k < nstops; k++) begin
      @(posedge wclk); sdi = 1'b1;
    end
  endtask

  task automatic send_ok(input logic [2:0] id, input logic [11:0] p, string tag);
    send(id, p, 16, 1'b1);
    #1;
    chk("R3", "upd before 16th stop sampled", int'(upd), 0);
    @(posedge wclk); #1;
    chk("R3", "upd after 16th stop", int'(upd), 1);
    chk(tag, "pending expected items", exp_q.size(), 0);
  endtask

  // monitor: pops expected group on every strobe
  always @(posedge wclk) begin
    if (!rst && upd) begin
      if (exp_q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R5 unexpected strobe: actual upd_id %0d expected none", upd_id);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk("R6", "upd_id", int'(upd_id), int'(e));
        compare_all("R2");
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge wclk);
    rst = 1'b0;
    @(posedge wclk); #1;
    compare_all("R12");
    chk("R12", "upd", int'(upd), 0);

    // long idle high run must not open a frame
    repeat (40) @(posedge wclk);
    #1; compare_all("R1");

    // receive group: gain 31, insel 01, ext 10, route 11
    send_ok(3'd0, {1'b0, 2'b11, 2'b10, 2'b01, 5'd31}, "R7");
    // transmit group: code 0 (-15 dB) then code 15 (0 dB)
    send_ok(3'd1, {5'd0, 3'b101, 4'd0}, "R8");
    send_ok(3'd1, {5'd0, 3'b010, 4'd15}, "R8");
    // general group
    send_ok(3'd2, {7'd0, 1'b1, 1'b1, 1'b1, 2'b01}, "R9");
    // trim group: lo -4, hi +3, test field 1010, test mode off
    send_ok(3'd3, {2'b00, 4'b1010, 3'b011, 3'b100}, "R10");
    chk("R10", "lo_cut", int'(lo_cut), -4);
    chk("R10", "hi_cut", int'(hi_cut), 3);
    chk("R11", "test_ctl gated", int'(test_ctl), 0);
    @(posedge wclk); test_en = 1'b1; #1;
    chk("R11", "test_ctl visible", int'(test_ctl), 10);
    @(posedge wclk); test_en = 1'b0; #1;
    chk("R11", "test_ctl regated", int'(test_ctl), 0);
    // tuning DAC and power-down groups
    send_ok(3'd4, 12'h0A5, "R13");
    send_ok(3'd5, 12'hC3A, "R13");

    // unused identifiers change nothing
    send(3'd6, 12'hFFF, 16, 1'b0);
    send(3'd7, 12'hFFF, 16, 1'b0);
    repeat (3) @(posedge wclk);
    #1; compare_all("R5");

    // frame cut at 15 stops is dropped; the low opens the next frame
    send(3'd0, 12'h007, 15, 1'b0);
    send_ok(3'd1, {5'd0, 3'b111, 4'd9}, "R4");
    compare_all("R4");
    // frame cut after 3 stops is dropped too
    send(3'd5, 12'h000, 3, 1'b0);
    send_ok(3'd4, 12'h03C, "R4");
    compare_all("R4");
    chk("R4", "rx_gain kept", int'(rx_gain), 31);
    chk("R4", "pd kept", int'(pd), 12'hC3A);

    // a second receive write in the opposite bit pattern
    send_ok(3'd0, {1'b1, 2'b00, 2'b01, 2'b10, 5'd0}, "R2");
    repeat (4) @(posedge wclk);
    #1; compare_all("R7");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule